// File: doc/BRIEF.md
# Single-Bus Accumulator Processor

A 16-bit accumulator machine in which every register transfer runs over one shared internal bus. The program counter, memory address register, memory data register, instruction register, accumulator and an ALU result register all sit on that bus. The block also contains a word-addressed program and data memory. Each instruction word holds a 4-bit operation code in bits 15:12 and a 12-bit word address in bits 11:0.

Instructions are sequenced by a one-hot ring of eight phase flip-flops. The ring moves one position per clock. The decoded operation code gates each phase to produce the transfer enables. Every instruction starts with the same five fetch phases and returns the ring to its first phase once its last step is done. A halt instruction freezes the ring and raises `halted` until reset.

Memory is filled and read back through a side port. The bench uses this port to load programs and data and to inspect results. When the port is active, it takes priority over the core's own memory write.

Top module: `bus_acc_core`

## Requirements
- R1: An active-low `rst_n` clears the program counter, accumulator and ALU register, sets the ring to its first phase and drives `halted` low. The first instruction is fetched from address 0, so a store executed before any load writes 0.
- R2: An instruction word carries its operation code in bits 15:12 and its address in bits 11:0.
- R3: Fetch takes five clocks, in this order:
  1. The PC goes to the address register.
  2. Memory is read into the data register and the PC increments.
  3. The data register goes to the instruction register.
  4. The address field goes to the address register.
  5. The operation is decoded.
- R4: Code 1 (store) moves the accumulator into the data register and then writes it to memory at the address. The whole instruction takes 7 clocks.
- R5: Code 2 (load) reads memory at the address and then copies the word into the accumulator. The whole instruction takes 7 clocks.
- R6: Code 3 (add) reads memory, forms the sum with the accumulator modulo 2^16 in the ALU register, and then moves the sum into the accumulator. The whole instruction takes 8 clocks.
- R7: Code 4 (halt) raises `halted` at the end of its sixth clock. After that, `halted`, the PC and the ring hold, and the core writes no memory, until reset.
- R8: Code 5 (jump) loads the PC from the address field. The whole instruction takes 6 clocks.
- R9: Codes 0 and 6 to 15 change no register and no memory word, and each takes 6 clocks.
- R10: At most one source drives the shared bus in any clock.
- R11: The phase ring is always one-hot. While the core runs, each clock moves the ring to the next phase or back to the first.
- R12: While `ld_en` is high, `ld_wr` high writes `ld_wdata` to `ld_addr`. `ld_rdata` shows the word at `ld_addr` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halted | output | 1 | High once a halt instruction has executed |
| ld_en | input | 1 | Side memory port select |
| ld_wr | input | 1 | Side port write strobe |
| ld_addr | input | 12 | Side port word address |
| ld_wdata | input | 16 | Side port write data |
| ld_rdata | output | 16 | Side port read data, one clock after the address |

## Verification
The assertions check on every cycle that the bus has at most one driver and that the phase ring stays one-hot and steps correctly. They also check that the PC increments during the memory-read phase of fetch, and that a halted core stays frozen and never writes memory. Only the bench's programs can show the data results of store, load, add, jump and the no-op codes, and the exact clock count of each instruction. The bench compares memory contents and the time to halt against an instruction-level model that runs random and directed programs.

// File: rtl/bus_acc_core.sv
module bus_acc_core #(
  parameter int DW  = 16,
  parameter int AW  = 12,
  parameter int OPW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          halted,
  input  logic          ld_en,
  input  logic          ld_wr,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_wdata,
  output logic [DW-1:0] ld_rdata
);
  localparam int NPH   = 8;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]  mem [DEPTH];
  logic [AW-1:0]  pc, mar;
  logic [DW-1:0]  mdr, ir, acc, c_q, bus;
  logic [NPH-1:0] ph, ph_nx;
  logic [OPW-1:0] op;

  assign op = ir[DW-1 -: OPW];

  logic is_st, is_ld, is_add, is_hlt, is_jmp, is_nop;
  assign is_st  = op == OPW'(1);
  assign is_ld  = op == OPW'(2);
  assign is_add = op == OPW'(3);
  assign is_hlt = op == OPW'(4);
  assign is_jmp = op == OPW'(5);
  assign is_nop = !(is_st || is_ld || is_add || is_hlt || is_jmp);

  logic e_mar_pc, e_mem_rd, e_pc_inc, e_ir, e_mar_ir, e_mdr_a, e_mem_wr;
  logic e_a_mdr, e_c, e_a_c, e_pc_ir, e_halt, last;
  assign e_mar_pc = ph[0];
  assign e_mem_rd = ph[1] | (ph[5] & (is_ld | is_add));
  assign e_pc_inc = ph[1];
  assign e_ir     = ph[2];
  assign e_mar_ir = ph[3];
  assign e_mdr_a  = ph[5] & is_st;
  assign e_pc_ir  = ph[5] & is_jmp;
  assign e_halt   = ph[5] & is_hlt;
  assign e_mem_wr = ph[6] & is_st;
  assign e_a_mdr  = ph[6] & is_ld;
  assign e_c      = ph[6] & is_add;
  assign e_a_c    = ph[7] & is_add;
  assign last     = ph[7] | (ph[6] & (is_st | is_ld)) | (ph[5] & (is_jmp | is_nop));

  logic src_pc, src_mdr, src_ir, src_acc, src_c;
  assign src_pc  = e_mar_pc;
  assign src_mdr = e_ir | e_a_mdr;
  assign src_ir  = e_mar_ir | e_pc_ir;
  assign src_acc = e_mdr_a;
  assign src_c   = e_a_c;

  assign bus = ({DW{src_pc}}  & DW'(pc))
             | ({DW{src_mdr}} & mdr)
             | ({DW{src_ir}}  & DW'(ir[AW-1:0]))
             | ({DW{src_acc}} & acc)
             | ({DW{src_c}}   & c_q);

  always_comb begin
    if (halted || e_halt) ph_nx = ph;
    else if (last)        ph_nx = NPH'(1);
    else                  ph_nx = {ph[NPH-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0; mar <= '0; mdr <= '0; ir <= '0;
      acc <= '0; c_q <= '0; ph <= NPH'(1); halted <= 1'b0;
    end else begin
      if (e_mar_pc || e_mar_ir) mar <= bus[AW-1:0];
      if (e_pc_inc)      pc <= pc + 1'b1;
      else if (e_pc_ir)  pc <= bus[AW-1:0];
      if (e_mem_rd)      mdr <= mem[mar];
      else if (e_mdr_a)  mdr <= bus;
      if (e_ir)          ir <= bus;
      if (e_a_mdr || e_a_c) acc <= bus;
      if (e_c)           c_q <= acc + mdr;
      if (e_halt)        halted <= 1'b1;
      ph <= ph_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_en) begin
      if (ld_wr) mem[ld_addr] <= ld_wdata;
      ld_rdata <= mem[ld_addr];
    end else if (e_mem_wr) begin
      mem[mar] <= mdr;
    end
  end
endmodule

// File: rtl/bus_acc_core_chk.sv
module bus_acc_core_chk #(
  parameter int AW  = 12,
  parameter int NPH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           halted,
  input logic [NPH-1:0] ph,
  input logic [AW-1:0]  pc,
  input logic [4:0]     srcs,
  input logic           mem_wr,
  input logic           ld_en
);
  p_one_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(srcs));

  p_ring_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(ph));

  p_ring_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !halted |=> (ph == {$past(ph[NPH-2:0]), 1'b0}) || (ph == NPH'(1)) || halted);

  p_fetch_seq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && (ph[0] || ph[1] || ph[2] || ph[3])) |=> (ph == {$past(ph[NPH-2:0]), 1'b0}));

  p_pc_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph[1] && !halted) |=> pc == $past(pc) + 1'b1);

  p_halt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(pc) && $stable(ph));

  p_halt_nowr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !ld_en) |-> !mem_wr);
endmodule

bind bus_acc_core bus_acc_core_chk #(.AW(AW), .NPH(NPH)) u_chk (
  .clk(clk), .rst_n(rst_n), .halted(halted), .ph(ph), .pc(pc),
  .srcs({src_pc, src_mdr, src_ir, src_acc, src_c}),
  .mem_wr(e_mem_wr), .ld_en(ld_en)
);

// File: tb/bus_acc_core_bench.sv
module bus_acc_core_bench;
  logic clk = 0, rst_n = 0, halted;
  logic ld_en = 0, ld_wr = 0;
  logic [11:0] ld_addr = '0;
  logic [15:0] ld_wdata = '0, ld_rdata;
  int total = 0, bad = 0;
  logic [15:0] img [4096];
  int exp_cyc;

  always #2 clk = ~clk;

  bus_acc_core u_bus_acc_core (.clk(clk), .rst_n(rst_n), .halted(halted),
    .ld_en(ld_en), .ld_wr(ld_wr), .ld_addr(ld_addr), .ld_wdata(ld_wdata),
    .ld_rdata(ld_rdata));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ins(int op, int a);
    return {4'(op), 12'(a)};
  endfunction

  // instruction-level model: updates img, returns clocks until halted
  task automatic model(output int cyc);
    logic [11:0] pc = 0;
    logic [15:0] acc = 0, w;
    cyc = 0;
    for (int n = 0; n < 1000; n++) begin
      w = img[pc]; pc++;
      case (w[15:12])
        4'd1: begin img[w[11:0]] = acc; cyc += 7; end
        4'd2: begin acc = img[w[11:0]]; cyc += 7; end
        4'd3: begin acc = acc + img[w[11:0]]; cyc += 8; end
        4'd4: begin cyc += 6; return; end
        4'd5: begin pc = w[11:0]; cyc += 6; end
        default: cyc += 6;
      endcase
    end
  endtask

  task automatic run_prog(input string tag);
    int cyc;
    logic [15:0] pre [128];
    rst_n = 0;
    for (int i = 0; i < 128; i++) begin
      int a = (i < 64) ? i : 448 + i;
      pre[i] = img[a];
      @(negedge clk); ld_en = 1; ld_wr = 1; ld_addr = 12'(a); ld_wdata = img[a];
    end
    @(negedge clk); ld_en = 0; ld_wr = 0;
    chk(halted == 0, "R1", {tag, " halted in reset"}, int'(halted), 0);
    model(exp_cyc);
    @(negedge clk); rst_n = 1;
    cyc = 0;
    while (cyc < 3000) begin
      @(posedge clk); cyc++;
      @(negedge clk);
      if (halted) break;
    end
    chk(cyc == exp_cyc, "R11", {tag, " clocks to halt"}, cyc, exp_cyc);
    repeat (20) @(negedge clk);
    chk(halted == 1, "R7", {tag, " halted holds"}, int'(halted), 1);
    for (int i = 0; i < 128; i++) begin
      int a = (i < 64) ? i : 448 + i;
      ld_en = 1; ld_addr = 12'(a);
      @(negedge clk);
      chk(ld_rdata == img[a], (i < 64) ? "R12" : "R4", {tag, " memory word"},
          int'(ld_rdata), int'(img[a]));
    end
    ld_en = 0;
  endtask

  task automatic clear_img();
    for (int i = 0; i < 64; i++) begin img[i] = ins(4, 0); img[512 + i] = 16'(i * 3); end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    // R1: store before any load writes zero accumulator
    clear_img(); img[0] = ins(1, 520); img[1] = ins(4, 0);
    run_prog("R1 reset acc");
    // R6: add wraps modulo 2^16; R5 load
    clear_img(); img[512] = 16'hFFFF; img[513] = 16'h0002;
    img[0] = ins(2, 512); img[1] = ins(3, 513); img[2] = ins(1, 514); img[3] = ins(4, 0);
    run_prog("R6 add wrap");
    // R8: jump over a halt
    clear_img(); img[512] = 16'hBEEF;
    img[0] = ins(5, 2); img[1] = ins(4, 0); img[2] = ins(2, 512);
    img[3] = ins(1, 515); img[4] = ins(4, 0);
    run_prog("R8 jump");
    // R9: reserved and undefined codes are no-ops; R2 field split
    clear_img(); img[512] = 16'h1234;
    img[0] = ins(2, 512); img[1] = ins(0, 513); img[2] = ins(6, 514);
    img[3] = ins(15, 515); img[4] = ins(1, 516); img[5] = ins(4, 0);
    run_prog("R9 nop codes");
    // random programs (R2 R3 R4 R5 R6 R8 R9)
    for (int p = 0; p < 8; p++) begin
      int n = 24;
      for (int i = 0; i < 64; i++) begin img[i] = ins(4, 0); img[512 + i] = 16'($urandom); end
      for (int i = 0; i < n - 1; i++) begin
        int r = $urandom % 10;
        int a = 512 + ($urandom % 64);
        case (r)
          0, 1, 2: img[i] = ins(1, a);
          3, 4, 9: img[i] = ins(2, a);
          5, 6:    img[i] = ins(3, a);
          7: begin
            int t = i + 1 + ($urandom % 3);
            if (t > n - 1) t = n - 1;
            img[i] = ins(5, t);
          end
          default: img[i] = ins((($urandom % 2) == 0) ? 0 : 6 + ($urandom % 10), a);
        endcase
      end
      img[n - 1] = ins(4, 0);
      run_prog("random");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule